// File: doc/BRIEF.md
# ECC Memory Fill Sequencer

This block brings up ECC-protected memory after reset. It writes a known pattern over up to two address ranges, so that no later read hits a location whose check bits were never computed. It does not move data itself. It drives the register port of a separate fill DMA channel, which does the writing, and walks that channel through a fixed script, one chunk at a time.

For each range the sequencer first returns the channel registers it uses to their reset values. It then cuts the length into pieces no larger than the channel accepts. For each piece it does the following, in order:

- waits for the channel to report a quiet state;
- programs a write-only fill of that piece;
- starts the channel and polls for completion;
- acknowledges completion and reads back the channel state.

A hardware error reported at the end of a piece makes the whole range start again from its base address, once. A second error, or a poll that outlasts its time limit, abandons the range and raises a sticky error flag. Two outputs report the result, a completion flag and an error flag, which the rest of the chip can sample.

Top module: `meminit_seq`

## Requirements
- R1: While reset is held, and in the first cycle after it is released, `init_done`, `init_error` and `reg_req` are all 0.
- R2: A range whose length is 0 causes no register transaction. With both lengths at 0, `init_done` rises with no bus traffic at all.
- R3: A range is cut into pieces of at most `MAX_CHUNK` bytes (default 0x3FFFFFF8). Every piece except the last has exactly that size. The last piece carries the remainder. The destination address advances by the size of each piece.
- R4: Before each piece the channel state register (offset 0x11C, bits [1:0]) is read repeatedly until it shows 00 or 11. A read that fails once `IDLE_TO` cycles have passed in this poll abandons the range with an error, and the piece is never programmed.
- R5: Each piece is programmed by the following sequence of register accesses, in order:
  - a read of control 0 (0x110), then a write of control 0 with (read value & 0x70) | 0x10;
  - 0xDEADBEEF written to the pattern words 0x148, 0x14C, 0x150 and 0x154;
  - destination address bits [31:0] written to 0x138, then bits [48:32] to 0x13C;
  - the piece size written to 0x130 and then to 0x140;
  - a read of control 2 (0x200), then a write of that value with bit 0 set.
- R6: After the start write, interrupt status (0x100) is read until bit 10 is 1. A read that fails once `DONE_TO` cycles have passed in this poll abandons the range with an error. `DONE_TO` defaults to five times `IDLE_TO`.
- R7: Once bit 10 is seen, the next transaction writes 0x400 to 0x100, and the one after it reads the state register.
- R8: If that state read shows 11, the range restarts from its base address with its full length. This restart happens at most once per range. A second error abandons the range with an error.
- R9: At the start of every attempt on a range, and again when the range ends (whether it completed or was abandoned), ten writes restore the channel: 0x80 to 0x110, then 0 to 0x148, 0x14C, 0x150, 0x154, 0x138, 0x13C, 0x130, 0x140 and 0x188.
- R10: Range 0 is finished completely, including its closing restore, before any transaction for range 1.
- R11: `init_done` rises once both ranges are finished and then stays 1, with no further transactions. `init_error` is set by any abandoned range and stays 1 until reset.
- R12: A request holds `reg_we`, `reg_addr` and `reg_wdata` stable, and `reg_req` high, until the cycle in which `reg_ack` is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bank0_base | input | ADDR_W | Start address of range 0 |
| bank0_len | input | LEN_W | Byte length of range 0; 0 skips the range |
| bank1_base | input | ADDR_W | Start address of range 1 |
| bank1_len | input | LEN_W | Byte length of range 1; 0 skips the range |
| reg_req | output | 1 | Register transaction request |
| reg_we | output | 1 | 1 for a write, 0 for a read |
| reg_addr | output | 12 | Channel register offset |
| reg_wdata | output | 32 | Write data |
| reg_ack | input | 1 | Transaction accepted; read data valid |
| reg_rdata | input | 32 | Read data |
| init_done | output | 1 | Both ranges finished |
| init_error | output | 1 | At least one range was abandoned |

## Verification
The bound checker watches the following on every cycle:
- the request stays stable until it is acknowledged;
- both result flags are sticky, and the bus is silent once the work is finished;
- every programmed piece has a size that is neither 0 nor above the limit;
- any poll timeout is followed by the error flag;
- no range is restarted a second time.

The exact order and values of the register script are visible only in the bench's scenarios, against a behavioural channel model whose answers the bench controls. The same holds for:
- the split into pieces and the address arithmetic across a piece boundary;
- the skipping of empty ranges;
- the acceptance of the 11 state while polling for a quiet channel;
- the restart from the base address;
- the relative length of the two timeout windows.

// File: rtl/meminit_pkg.sv
package meminit_pkg;

  localparam logic [11:0] OFF_ISR    = 12'h100;
  localparam logic [11:0] OFF_CTRL0  = 12'h110;
  localparam logic [11:0] OFF_STATE  = 12'h11C;
  localparam logic [11:0] OFF_SRCSZ  = 12'h130;
  localparam logic [11:0] OFF_DSTLO  = 12'h138;
  localparam logic [11:0] OFF_DSTHI  = 12'h13C;
  localparam logic [11:0] OFF_DSTSZ  = 12'h140;
  localparam logic [11:0] OFF_PAT0   = 12'h148;
  localparam logic [11:0] OFF_TOTAL  = 12'h188;
  localparam logic [11:0] OFF_CTRL2  = 12'h200;

  localparam logic [31:0] FILL_WORD    = 32'hDEAD_BEEF;
  localparam logic [31:0] CTRL0_RESET  = 32'h0000_0080;
  localparam logic [31:0] CTRL0_KEEP   = 32'h0000_0070;
  localparam logic [31:0] CTRL0_WRONLY = 32'h0000_0010;
  localparam logic [31:0] DSTHI_MASK   = 32'h0001_FFFF;
  localparam logic [31:0] ISR_DONE     = 32'h0000_0400;
  localparam int          ISR_DONE_BIT = 10;

  localparam logic [3:0] RESTORE_LAST = 4'd9;
  localparam logic [3:0] PROG_LAST    = 4'd11;

  typedef enum logic [3:0] {
    PH_BANK, PH_RST_A, PH_IDLE, PH_PROG, PH_DONE,
    PH_CLR, PH_STAT, PH_RST_B, PH_NEXT, PH_FIN
  } phase_e;

  typedef struct packed {
    logic        we;
    logic [11:0] addr;
    logic [31:0] data;
  } bus_op_t;

  // Size of the next piece: whole remainder or the cap, whichever is smaller.
  function automatic logic [31:0] chunk_of(input logic [63:0] rem, input logic [31:0] cap);
    return (rem > {32'h0, cap}) ? cap : rem[31:0];
  endfunction

  function automatic logic [31:0] ctrl0_merge(input logic [31:0] rd);
    return (rd & CTRL0_KEEP) | CTRL0_WRONLY;
  endfunction

  function automatic bus_op_t restore_op(input logic [3:0] step);
    bus_op_t op;
    op.we   = 1'b1;
    op.data = 32'h0;
    case (step)
      4'd0: begin op.addr = OFF_CTRL0; op.data = CTRL0_RESET; end
      4'd1, 4'd2, 4'd3, 4'd4: op.addr = OFF_PAT0 + {6'd0, step - 4'd1, 2'b00};
      4'd5: op.addr = OFF_DSTLO;
      4'd6: op.addr = OFF_DSTHI;
      4'd7: op.addr = OFF_SRCSZ;
      4'd8: op.addr = OFF_DSTSZ;
      default: op.addr = OFF_TOTAL;
    endcase
    return op;
  endfunction

  function automatic bus_op_t prog_op(input logic [3:0] step, input logic [31:0] hold,
                                      input logic [63:0] dst, input logic [31:0] clen);
    bus_op_t op;
    op.we   = 1'b1;
    op.data = 32'h0;
    op.addr = OFF_STATE;
    case (step)
      4'd0:  begin op.we = 1'b0; op.addr = OFF_CTRL0; end
      4'd1:  begin op.addr = OFF_CTRL0; op.data = ctrl0_merge(hold); end
      4'd2, 4'd3, 4'd4, 4'd5: begin
        op.addr = OFF_PAT0 + {6'd0, step - 4'd2, 2'b00};
        op.data = FILL_WORD;
      end
      4'd6:  begin op.addr = OFF_DSTLO; op.data = dst[31:0]; end
      4'd7:  begin op.addr = OFF_DSTHI; op.data = dst[63:32] & DSTHI_MASK; end
      4'd8:  begin op.addr = OFF_SRCSZ; op.data = clen; end
      4'd9:  begin op.addr = OFF_DSTSZ; op.data = clen; end
      4'd10: begin op.we = 1'b0; op.addr = OFF_CTRL2; end
      default: begin op.addr = OFF_CTRL2; op.data = hold | 32'h1; end
    endcase
    return op;
  endfunction

endpackage

// File: rtl/meminit_chunker.sv
module meminit_chunker #(
  parameter int          ADDR_W    = 49,
  parameter int          LEN_W     = 40,
  parameter logic [31:0] MAX_CHUNK = 32'h3FFF_FFF8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [ADDR_W-1:0] base,
  input  logic [LEN_W-1:0]  len,
  input  logic              advance,
  output logic [ADDR_W-1:0] cur_addr,
  output logic [31:0]       chunk_len,
  output logic              last
);
  import meminit_pkg::*;

  logic [LEN_W-1:0] remain_q;

  assign chunk_len = chunk_of(64'(remain_q), MAX_CHUNK);
  assign last      = (64'(remain_q) == 64'(chunk_len));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_addr <= '0;
      remain_q <= '0;
    end else if (load) begin
      cur_addr <= base;
      remain_q <= len;
    end else if (advance) begin
      cur_addr <= cur_addr + ADDR_W'(chunk_len);
      remain_q <= remain_q - LEN_W'(chunk_len);
    end
  end
endmodule

// File: rtl/meminit_poll_timer.sv
module meminit_poll_timer #(
  parameter int CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [CNT_W-1:0] limit,
  output logic             expired
);
  logic [CNT_W-1:0] cnt_q;

  assign expired = (cnt_q >= limit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                cnt_q <= '0;
    else if (!run)             cnt_q <= '0;
    else if (cnt_q != '1)      cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/meminit_seq.sv
module meminit_seq #(
  parameter int          ADDR_W    = 49,
  parameter int          LEN_W     = 40,
  parameter logic [31:0] MAX_CHUNK = 32'h3FFF_FFF8,
  parameter int          IDLE_TO   = 1000,
  parameter int          DONE_TO   = 5 * IDLE_TO
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bank0_base,
  input  logic [LEN_W-1:0]  bank0_len,
  input  logic [ADDR_W-1:0] bank1_base,
  input  logic [LEN_W-1:0]  bank1_len,
  output logic              reg_req,
  output logic              reg_we,
  output logic [11:0]       reg_addr,
  output logic [31:0]       reg_wdata,
  input  logic              reg_ack,
  input  logic [31:0]       reg_rdata,
  output logic              init_done,
  output logic              init_error
);
  import meminit_pkg::*;

  localparam int CNT_W = $clog2(DONE_TO + 1) + 1;

  phase_e      phase_q;
  logic [3:0]  step_q;
  logic        bank_q, retried_q, err_q, done_q;
  logic [31:0] hold_q;
  bus_op_t     op;

  logic [ADDR_W-1:0] cur_base, cur_addr;
  logic [LEN_W-1:0]  cur_len;
  logic [31:0]       chunk_len;
  logic              chunk_last, tmr_run, tmr_expired;
  logic [CNT_W-1:0]  tmr_limit;

  // Named internal events, used by the FSM and by the checker.
  logic ack_ev, idle_ok, stat_err, ev_bank_start, ev_timeout, ev_retry, ev_fail, ev_advance;
  logic in_prog;

  assign cur_base = bank_q ? bank1_base : bank0_base;
  assign cur_len  = bank_q ? bank1_len  : bank0_len;

  assign ack_ev        = reg_req && reg_ack;
  assign idle_ok       = (reg_rdata[1:0] == 2'b00) || (reg_rdata[1:0] == 2'b11);
  assign stat_err      = (reg_rdata[1:0] == 2'b11);
  assign ev_bank_start = (phase_q == PH_BANK) && (cur_len != '0);
  assign ev_timeout    = ack_ev && tmr_expired &&
                         (((phase_q == PH_IDLE) && !idle_ok) ||
                          ((phase_q == PH_DONE) && !reg_rdata[ISR_DONE_BIT]));
  assign ev_retry      = ack_ev && (phase_q == PH_STAT) && stat_err && !retried_q;
  assign ev_fail       = ack_ev && (phase_q == PH_STAT) && stat_err && retried_q;
  assign ev_advance    = ack_ev && (phase_q == PH_STAT) && !stat_err && !chunk_last;
  assign in_prog       = (phase_q == PH_PROG);

  assign tmr_run   = (phase_q == PH_IDLE) || (phase_q == PH_DONE);
  assign tmr_limit = (phase_q == PH_DONE) ? CNT_W'(DONE_TO) : CNT_W'(IDLE_TO);

  meminit_chunker #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .MAX_CHUNK(MAX_CHUNK)) u_chunk (
    .clk(clk), .rst_n(rst_n),
    .load(ev_bank_start || ev_retry), .base(cur_base), .len(cur_len),
    .advance(ev_advance),
    .cur_addr(cur_addr), .chunk_len(chunk_len), .last(chunk_last)
  );

  meminit_poll_timer #(.CNT_W(CNT_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .run(tmr_run), .limit(tmr_limit), .expired(tmr_expired)
  );

  always_comb begin
    op      = '0;
    reg_req = 1'b1;
    case (phase_q)
      PH_RST_A, PH_RST_B: op = restore_op(step_q);
      PH_IDLE: begin op.we = 1'b0; op.addr = OFF_STATE; end
      PH_PROG: op = prog_op(step_q, hold_q, 64'(cur_addr), chunk_len);
      PH_DONE: begin op.we = 1'b0; op.addr = OFF_ISR; end
      PH_CLR:  begin op.we = 1'b1; op.addr = OFF_ISR; op.data = ISR_DONE; end
      PH_STAT: begin op.we = 1'b0; op.addr = OFF_STATE; end
      default: reg_req = 1'b0;
    endcase
  end

  assign reg_we     = op.we;
  assign reg_addr   = op.addr;
  assign reg_wdata  = op.data;
  assign init_done  = done_q;
  assign init_error = err_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q   <= PH_BANK;
      step_q    <= '0;
      bank_q    <= 1'b0;
      retried_q <= 1'b0;
      err_q     <= 1'b0;
      done_q    <= 1'b0;
      hold_q    <= '0;
    end else begin
      if (ev_timeout || ev_fail) begin
        err_q   <= 1'b1;
        step_q  <= '0;
        phase_q <= PH_RST_B;
      end else begin
        case (phase_q)
          PH_BANK: begin
            step_q    <= '0;
            retried_q <= 1'b0;
            phase_q   <= ev_bank_start ? PH_RST_A : PH_NEXT;
          end
          PH_RST_A: if (ack_ev) begin
            if (step_q == RESTORE_LAST) begin
              step_q  <= '0;
              phase_q <= PH_IDLE;
            end else step_q <= step_q + 4'd1;
          end
          PH_IDLE: if (ack_ev && idle_ok) begin
            step_q  <= '0;
            phase_q <= PH_PROG;
          end
          PH_PROG: if (ack_ev) begin
            if (!op.we) hold_q <= reg_rdata;
            if (step_q == PROG_LAST) phase_q <= PH_DONE;
            else step_q <= step_q + 4'd1;
          end
          PH_DONE: if (ack_ev && reg_rdata[ISR_DONE_BIT]) phase_q <= PH_CLR;
          PH_CLR:  if (ack_ev) phase_q <= PH_STAT;
          PH_STAT: if (ack_ev) begin
            step_q <= '0;
            if (ev_retry) begin
              retried_q <= 1'b1;
              phase_q   <= PH_RST_A;
            end else if (chunk_last) phase_q <= PH_RST_B;
            else phase_q <= PH_IDLE;
          end
          PH_RST_B: if (ack_ev) begin
            if (step_q == RESTORE_LAST) phase_q <= PH_NEXT;
            else step_q <= step_q + 4'd1;
          end
          PH_NEXT: begin
            if (!bank_q) begin
              bank_q  <= 1'b1;
              phase_q <= PH_BANK;
            end else begin
              done_q  <= 1'b1;
              phase_q <= PH_FIN;
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/meminit_seq_chk.sv
module meminit_seq_chk #(
  parameter logic [31:0] MAX_CHUNK = 32'h3FFF_FFF8
) (
  input logic        clk,
  input logic        rst_n,
  input logic        reg_req,
  input logic        reg_we,
  input logic [11:0] reg_addr,
  input logic [31:0] reg_wdata,
  input logic        reg_ack,
  input logic        init_done,
  input logic        init_error,
  input logic        in_prog,
  input logic [31:0] chunk_len,
  input logic        ev_bank_start,
  input logic        ev_timeout,
  input logic        ev_retry
);
  logic [1:0] retries_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             retries_q <= '0;
    else if (ev_bank_start) retries_q <= '0;
    else if (ev_retry && retries_q != 2'd3) retries_q <= retries_q + 2'd1;
  end

  p_req_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    reg_req && !reg_ack |=> reg_req && $stable(reg_we) && $stable(reg_addr) && $stable(reg_wdata));

  p_done_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
    init_done |=> init_done);

  p_done_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
    init_done |-> !reg_req);

  p_err_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
    init_error |=> init_error);

  p_chunk_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
    in_prog |-> (chunk_len != 32'h0) && (chunk_len <= MAX_CHUNK));

  p_timeout_flags_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ev_timeout |=> init_error);

  p_single_retry_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ev_retry |-> retries_q == 2'd0);
endmodule

bind meminit_seq meminit_seq_chk #(.MAX_CHUNK(MAX_CHUNK)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_req(reg_req), .reg_we(reg_we), .reg_addr(reg_addr),
  .reg_wdata(reg_wdata), .reg_ack(reg_ack), .init_done(init_done), .init_error(init_error),
  .in_prog(in_prog), .chunk_len(chunk_len), .ev_bank_start(ev_bank_start),
  .ev_timeout(ev_timeout), .ev_retry(ev_retry)
);

// File: tb/meminit_seq_test.sv
`timescale 1ns/1ps
module meminit_seq_test;
  localparam logic [11:0] A_ISR = 12'h100, A_C0 = 12'h110, A_ST = 12'h11C, A_SSZ = 12'h130;
  localparam logic [11:0] A_DLO = 12'h138, A_DHI = 12'h13C, A_DSZ = 12'h140, A_P0 = 12'h148;
  localparam logic [11:0] A_TOT = 12'h188, A_C2 = 12'h200;
  localparam logic [31:0] NONE = 32'hFFFF_FFFF;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [48:0] b0_base = '0, b1_base = '0;
  logic [39:0] b0_len = '0, b1_len = '0;
  logic reg_req, reg_we, reg_ack, init_done, init_error;
  logic [11:0] reg_addr;
  logic [31:0] reg_wdata, reg_rdata;

  int checks = 0, fails = 0;

  // Channel model state
  int busy_left, err_left, isr_reads;
  bit isr_never, after_clr;
  logic [1:0] chan;
  logic [31:0] m_c0, m_c2, m_rv;
  int n_ops;
  logic op_we [0:511];
  logic [11:0] op_addr [0:511];
  logic [31:0] op_data [0:511];

  always #4 clk = ~clk;

  meminit_seq #(.IDLE_TO(20), .DONE_TO(100)) uut (
    .clk(clk), .rst_n(rst_n), .bank0_base(b0_base), .bank0_len(b0_len),
    .bank1_base(b1_base), .bank1_len(b1_len), .reg_req(reg_req), .reg_we(reg_we),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_ack(reg_ack), .reg_rdata(reg_rdata),
    .init_done(init_done), .init_error(init_error)
  );

  initial begin
    reg_ack = 1'b0;
    reg_rdata = '0;
    forever begin
      @(posedge clk);
      if (!rst_n) reg_ack <= 1'b0;
      else if (reg_req && !reg_ack) begin
        m_rv = 32'h0;
        if (reg_we) begin
          if (reg_addr == A_C0) m_c0 = reg_wdata;
          if (reg_addr == A_C2) begin m_c2 = reg_wdata; if (reg_wdata[0]) isr_reads = 0; end
          if (reg_addr == A_ISR && reg_wdata[10]) after_clr = 1'b1;
          m_rv = reg_wdata;
        end else if (reg_addr == A_C0) m_rv = m_c0;
        else if (reg_addr == A_C2) m_rv = m_c2;
        else if (reg_addr == A_ISR) begin
          isr_reads++;
          if (!isr_never && isr_reads >= 2) begin m_rv = 32'h400; m_c2[0] = 1'b0; end
        end else if (reg_addr == A_ST) begin
          if (after_clr) begin
            after_clr = 1'b0;
            if (err_left > 0) begin err_left--; chan = 2'b11; end
            else chan = 2'b00;
            m_rv = {30'h0, chan};
          end else if (busy_left > 0) begin
            busy_left--;
            m_rv = 32'h1;
          end else m_rv = {30'h0, chan};
        end
        if (n_ops < 512) begin
          op_we[n_ops] = reg_we; op_addr[n_ops] = reg_addr; op_data[n_ops] = m_rv;
          n_ops++;
        end
        reg_ack   <= 1'b1;
        reg_rdata <= m_rv;
      end else reg_ack <= 1'b0;
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: run did not end act=hung exp=finished");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  function automatic int n_w(input logic [11:0] a, input logic [31:0] d);
    int c = 0;
    for (int i = 0; i < n_ops; i++) if (op_we[i] && op_addr[i] == a && op_data[i] == d) c++;
    return c;
  endfunction

  function automatic int n_wa(input logic [11:0] a);
    int c = 0;
    for (int i = 0; i < n_ops; i++) if (op_we[i] && op_addr[i] == a) c++;
    return c;
  endfunction

  function automatic int n_rd(input logic [11:0] a);
    int c = 0;
    for (int i = 0; i < n_ops; i++) if (!op_we[i] && op_addr[i] == a) c++;
    return c;
  endfunction

  function automatic int n_writes();
    int c = 0;
    for (int i = 0; i < n_ops; i++) if (op_we[i]) c++;
    return c;
  endfunction

  function automatic logic [31:0] nz_w(input logic [11:0] a, input int n);
    int k = 0;
    for (int i = 0; i < n_ops; i++)
      if (op_we[i] && op_addr[i] == a && op_data[i] != 32'h0) begin
        if (k == n) return op_data[i];
        k++;
      end
    return NONE;
  endfunction

  // Index of the nth write in the log
  function automatic int wi(input int n);
    int k = 0;
    for (int i = 0; i < n_ops; i++)
      if (op_we[i]) begin
        if (k == n) return i;
        k++;
      end
    return 0;
  endfunction

  task automatic run(input logic [48:0] ba0, input logic [39:0] l0, input logic [48:0] ba1,
                     input logic [39:0] l1, input int busy, input int errs, input bit never);
    @(negedge clk);
    rst_n = 1'b0;
    b0_base = ba0; b0_len = l0; b1_base = ba1; b1_len = l1;
    busy_left = busy; err_left = errs; isr_never = never; after_clr = 1'b0;
    chan = 2'b00; m_c0 = 32'h80; m_c2 = 32'h0; isr_reads = 0; n_ops = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    for (int i = 0; i < 20000 && !init_done; i++) @(negedge clk);
    chk(init_done === 1'b1, "R11 done after run", 64'(init_done), 1);
    repeat (4) @(negedge clk);
  endtask

  task automatic t_reset();
    @(negedge clk);
    rst_n = 1'b0;
    b0_len = 40'h100; b1_len = '0;
    repeat (2) @(negedge clk);
    chk(init_done == 1'b0 && init_error == 1'b0 && reg_req == 1'b0, "R1 reset outputs",
        {61'h0, init_done, init_error, reg_req}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(init_done == 1'b0 && init_error == 1'b0, "R1 first cycle", {62'h0, init_done, init_error}, 0);
  endtask

  task automatic t_basic();
    int x;
    run(49'h1_2345_6780, 40'h200, '0, '0, 3, 0, 1'b0);
    chk(init_error == 1'b0, "R11 no error", 64'(init_error), 0);
    chk(n_writes() == 31, "R2 write count with empty range 1", n_writes(), 31);
    x = wi(0);
    chk(op_addr[x] == A_C0 && op_data[x] == 32'h80, "R9 opening restore first", op_data[x], 32'h80);
    x = wi(9);
    chk(op_addr[x] == A_TOT && op_data[x] == 0, "R9 opening restore last", 64'(op_addr[x]), A_TOT);
    chk(!op_we[wi(10) - 1] && op_addr[wi(10) - 1] == A_C0, "R5 control 0 read before write",
        64'(op_addr[wi(10) - 1]), A_C0);
    x = wi(10);
    chk(op_addr[x] == A_C0 && op_data[x] == 32'h10, "R5 write-only mode", op_data[x], 32'h10);
    for (int k = 0; k < 4; k++) begin
      x = wi(11 + k);
      chk(op_addr[x] == A_P0 + 12'(4 * k) && op_data[x] == 32'hDEAD_BEEF, "R5 pattern word",
          op_data[x], 32'hDEAD_BEEF);
    end
    x = wi(15);
    chk(op_addr[x] == A_DLO && op_data[x] == 32'h2345_6780, "R5 dest low", op_data[x], 32'h2345_6780);
    x = wi(16);
    chk(op_addr[x] == A_DHI && op_data[x] == 32'h1, "R5 dest high", op_data[x], 1);
    x = wi(17);
    chk(op_addr[x] == A_SSZ && op_data[x] == 32'h200, "R5 source size", op_data[x], 32'h200);
    x = wi(18);
    chk(op_addr[x] == A_DSZ && op_data[x] == 32'h200, "R5 dest size", op_data[x], 32'h200);
    x = wi(19);
    chk(!op_we[x - 1] && op_addr[x - 1] == A_C2 && op_addr[x] == A_C2 && op_data[x] == 32'h1,
        "R5 enable read-modify-write", op_data[x], 1);
    x = wi(20);
    chk(op_addr[x] == A_ISR && op_data[x] == 32'h400, "R7 done clear", op_data[x], 32'h400);
    chk(!op_we[x - 1] && op_addr[x - 1] == A_ISR, "R6 done poll precedes clear", 64'(op_addr[x - 1]), A_ISR);
    chk(!op_we[x + 1] && op_addr[x + 1] == A_ST, "R7 state read after clear", 64'(op_addr[x + 1]), A_ST);
    chk(n_rd(A_ST) == 5, "R4 busy state re-polled", n_rd(A_ST), 5);
    chk(n_w(A_C0, 32'h80) == 2, "R9 closing restore", n_w(A_C0, 32'h80), 2);
  endtask

  task automatic t_chunks();
    run(49'h1_0000_1000, 40'h80_0000_00, '0, '0, 0, 0, 1'b0);
    chk(nz_w(A_SSZ, 0) == 32'h3FFF_FFF8, "R3 first piece full", nz_w(A_SSZ, 0), 32'h3FFF_FFF8);
    chk(nz_w(A_SSZ, 1) == 32'h3FFF_FFF8, "R3 second piece full", nz_w(A_SSZ, 1), 32'h3FFF_FFF8);
    chk(nz_w(A_SSZ, 2) == 32'h10, "R3 remainder", nz_w(A_SSZ, 2), 32'h10);
    chk(nz_w(A_SSZ, 3) == NONE, "R3 piece count", nz_w(A_SSZ, 3), NONE);
    chk(nz_w(A_DLO, 1) == 32'h4000_0FF8, "R3 address step", nz_w(A_DLO, 1), 32'h4000_0FF8);
    chk(nz_w(A_DLO, 2) == 32'h8000_0FF0, "R3 address step 2", nz_w(A_DLO, 2), 32'h8000_0FF0);
    chk(nz_w(A_DHI, 2) == 32'h1, "R5 dest high per piece", nz_w(A_DHI, 2), 1);
    chk(init_error == 1'b0, "R3 clean finish", 64'(init_error), 0);
  endtask

  task automatic t_order();
    run(49'h2000, 40'h40, 49'h1_0000_3000, 40'h80, 0, 0, 1'b0);
    chk(nz_w(A_DLO, 0) == 32'h2000 && nz_w(A_DLO, 1) == 32'h3000, "R10 range order",
        nz_w(A_DLO, 0), 32'h2000);
    chk(nz_w(A_SSZ, 0) == 32'h40 && nz_w(A_SSZ, 1) == 32'h80, "R10 sizes in order",
        nz_w(A_SSZ, 1), 32'h80);
    chk(n_w(A_C0, 32'h80) == 4, "R10 range 0 closed before range 1", n_w(A_C0, 32'h80), 4);
    chk(op_we[wi(31)] && op_addr[wi(31)] == A_C0 && op_data[wi(31)] == 32'h80,
        "R10 range 1 starts after range 0 closing restore", op_data[wi(31)], 32'h80);
  endtask

  task automatic t_retry();
    run(49'h5000, 40'h80, '0, '0, 0, 1, 1'b0);
    chk(init_error == 1'b0, "R8 single error recovered", 64'(init_error), 0);
    chk(nz_w(A_DLO, 0) == 32'h5000 && nz_w(A_DLO, 1) == 32'h5000, "R8 restart at base",
        nz_w(A_DLO, 1), 32'h5000);
    chk(n_w(A_C0, 32'h80) == 3, "R9 restore per attempt", n_w(A_C0, 32'h80), 3);
    chk(n_writes() == 52, "R8 retry write count", n_writes(), 52);
    chk(nz_w(A_SSZ, 1) == 32'h80, "R4 state 11 accepted as quiet", nz_w(A_SSZ, 1), 32'h80);
  endtask

  task automatic t_double_err();
    run(49'h5000, 40'h80_0000_00, '0, '0, 0, 2, 1'b0);
    chk(init_error == 1'b1, "R8 second error flagged", 64'(init_error), 1);
    chk(nz_w(A_SSZ, 2) == NONE, "R8 only two attempts", nz_w(A_SSZ, 2), NONE);
    chk(nz_w(A_DLO, 1) == 32'h5000, "R8 second attempt from base", nz_w(A_DLO, 1), 32'h5000);
    chk(n_w(A_C0, 32'h80) == 3, "R9 restore after abandon", n_w(A_C0, 32'h80), 3);
  endtask

  task automatic t_idle_to();
    run(49'h6000, 40'h100, '0, '0, 1000000, 0, 1'b0);
    chk(init_error == 1'b1, "R4 idle timeout flagged", 64'(init_error), 1);
    chk(n_wa(A_SSZ) == 2 && nz_w(A_SSZ, 0) == NONE, "R4 piece never programmed", n_wa(A_SSZ), 2);
    chk(n_rd(A_ST) >= 10 && n_rd(A_ST) <= 12, "R4 idle window length", n_rd(A_ST), 11);
    chk(n_w(A_C0, 32'h80) == 2, "R9 restore after idle timeout", n_w(A_C0, 32'h80), 2);
  endtask

  task automatic t_done_to();
    run(49'h7000, 40'h100, '0, '0, 0, 0, 1'b1);
    chk(init_error == 1'b1, "R6 done timeout flagged", 64'(init_error), 1);
    chk(n_rd(A_ISR) >= 50 && n_rd(A_ISR) <= 52, "R6 done window length", n_rd(A_ISR), 51);
    chk(n_wa(A_ISR) == 0, "R7 no clear without done", n_wa(A_ISR), 0);
  endtask

  task automatic t_empty();
    run(49'h8000, '0, 49'h9000, '0, 0, 0, 1'b0);
    chk(n_ops == 0, "R2 no transactions", n_ops, 0);
    chk(init_error == 1'b0, "R2 no error", 64'(init_error), 0);
    repeat (5) @(negedge clk);
    chk(init_done == 1'b1 && reg_req == 1'b0, "R11 stays done and quiet", 64'(reg_req), 0);
  endtask

  initial begin
    t_reset();
    t_basic();
    t_chunks();
    t_order();
    t_retry();
    t_double_err();
    t_idle_to();
    t_done_to();
    t_empty();
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule